// File: doc/BRIEF.md
# Table-Sequenced Nibble Accumulator Core

This block is a small Harvard-style processor with a 4-bit data path and an 8-bit instruction address. It has no program counter incrementer. Every instruction is a 16-way branch. The ALU turns the current accumulator and one data-memory nibble into a result and a 4-bit condition code. A jump table indexed by the current address and that condition code supplies the address of the next instruction. A second table, indexed by the current address alone, supplies the operation byte. That byte names the operand nibble, the ALU function and the destination. Each instruction takes one clock.

The jump table, the operation table and the 16-nibble data memory are internal arrays. They are filled through a load port before or between runs. A small mode machine sequences execution. Its states are ST_FILL (tables open to the load port, execution frozen), ST_SETTLE (one idle cycle after a load or after reset) and ST_EXEC (one instruction per clock). The transitions are:
- any state to ST_FILL while `load_en` is high;
- ST_FILL to ST_SETTLE when `load_en` is low;
- ST_SETTLE to ST_EXEC when `load_en` is low;
- ST_EXEC stays in ST_EXEC;
- reset enters ST_SETTLE.

The current address, the accumulator and the live condition code are brought out so that a bench can follow the execution trace.

Top module: `nbc_branch_core`

## Requirements
- R1: A synchronous reset sets the instruction address and the accumulator to 0 and enters ST_SETTLE. No instruction executes on the first rising edge after reset is released.
- R2: On each edge in ST_EXEC with `load_en` low, the instruction address loads the jump-table entry at the 13-bit index {1'b0, address[7:0], cond[3:0]}. Here `cond` is the condition code of the instruction being executed.
- R3: The operation byte at the current address holds the operand index in bits 7:4, the function in bits 3:1 and the destination in bit 0. With A the accumulator and M the operand nibble, all modulo 16, the functions are: 000 A+M, 001 ~(A^M), 010 (A&M)-1, 011 A&M, 100 (A|M)+A, 101 A|~M, 110 A-1, 111 A.
- R4: A destination bit of 0 writes the result to the accumulator. A destination bit of 1 writes it to the data nibble at the operand index and leaves the accumulator unchanged.
- R5: The condition code is formed from an addend pair (X, Y). The pair is (A,M) for 000, (A&M,15) for 010, (A|M,A) for 100, (A,15) for 110, and (A,M) for the non-arithmetic functions. The code bits are:
  - bit 3: 0 when the arithmetic functions produce a carry out of X+Y, 1 otherwise and always 1 for non-arithmetic functions;
  - bit 2: 1 when the result is 15;
  - bit 1: 1 when X&Y is nonzero;
  - bit 0: 1 when X|Y is 15.
- R6: While `load_en` is high, the address and the accumulator hold their values and `load_sel` picks the write target:
  - 00: jump-table entry `load_idx` gets `load_data[7:0]`;
  - 01: operation entry `load_idx[11:4]` gets `load_data[7:0]`;
  - 10: data nibble `load_idx[3:0]` gets `load_data[3:0]`;
  - 11: nothing is written.
- R7: A load write is ignored when `load_idx[12]` is 1 (jump or operation table) or when `load_idx[3:0]` is nonzero (operation table).
- R8: After `load_en` falls, one idle cycle (ST_SETTLE) passes before the next instruction executes.
- R9: Reset leaves both tables and the data memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load mode, freezes execution |
| load_sel | input | 2 | Load target select |
| load_idx | input | 13 | Load index in the 13-bit table layout |
| load_data | input | 8 | Load data |
| pc_o | output | 8 | Current instruction address |
| acc_o | output | 4 | Accumulator |
| cond_o | output | 4 | Condition code of the current instruction |

## Verification
The bench fills every table with random contents and then follows thousands of random 16-way branches against its own model. This exposes any mix-up between the condition bit order, the carry polarity or the G/P addend pairs, because each such error sends the address down a different jump-table entry. Ignored reserved-index writes are followed by execution that would read the wrong entries if the block had stored them. Loads in the middle of a run and resets in the middle of a run test the frozen address, the single settle cycle (a core that skips it gets one instruction ahead) and the retention of the tables across reset.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
    localparam int CC_W  = 4;
    localparam int FN_W  = 3;

    typedef enum logic [FN_W-1:0] {
        OP_SUM    = 3'b000,
        OP_XNOR   = 3'b001,
        OP_ANDDEC = 3'b010,
        OP_AND    = 3'b011,
        OP_ORADD  = 3'b100,
        OP_ORNOT  = 3'b101,
        OP_DEC    = 3'b110,
        OP_PASS   = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        LD_JUMP = 2'b00,
        LD_OPER = 2'b01,
        LD_DATA = 2'b10,
        LD_NONE = 2'b11
    } load_sel_e;

    typedef enum logic [1:0] {
        ST_FILL   = 2'b00,
        ST_SETTLE = 2'b01,
        ST_EXEC   = 2'b10
    } mode_e;
endpackage

// File: rtl/nbc_alu.sv
module nbc_alu
    import nbc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  opcode_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic [CC_W-1:0]   cc_o
);
    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic [DATA_W-1:0] logic_res;
    logic              is_arith;
    logic [DATA_W:0]   sum;
    logic              carry;

    // Operand pair selection and non-arithmetic results
    always_comb begin
        add_x     = acc_i;
        add_y     = opnd_i;
        is_arith  = 1'b0;
        logic_res = acc_i;
        unique case (op_i)
            OP_SUM:    is_arith = 1'b1;
            OP_XNOR:   logic_res = ~(acc_i ^ opnd_i);
            OP_ANDDEC: begin
                add_x    = acc_i & opnd_i;
                add_y    = '1;
                is_arith = 1'b1;
            end
            OP_AND:    logic_res = acc_i & opnd_i;
            OP_ORADD:  begin
                add_x    = acc_i | opnd_i;
                add_y    = acc_i;
                is_arith = 1'b1;
            end
            OP_ORNOT:  logic_res = acc_i | ~opnd_i;
            OP_DEC:    begin
                add_y    = '1;
                is_arith = 1'b1;
            end
            OP_PASS:   logic_res = acc_i;
            default:   logic_res = acc_i;
        endcase
    end

    assign sum   = {1'b0, add_x} + {1'b0, add_y};
    assign carry = is_arith & sum[DATA_W];
    assign res_o = is_arith ? sum[DATA_W-1:0] : logic_res;

    // bit3 active-low carry, bit2 all ones, bit1 any generate, bit0 all propagate
    assign cc_o = {~carry, &res_o, |(add_x & add_y), &(add_x | add_y)};

    always_comb begin
        if (op_i == OP_XNOR && acc_i == opnd_i) begin
            AST_XNOR_SELF_ONES: assert (res_o == '1); // R3
        end
        if (op_i == OP_DEC && acc_i == '0) begin
            AST_DEC_ZERO_NOCARRY: assert (cc_o[3] == 1'b1 && res_o == '1); // R5
        end
    end
endmodule

// File: rtl/nbc_store.sv
module nbc_store
    import nbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int OPND_W = 4,
    parameter int OPB_W  = 8,
    parameter int IDX_W  = 13,
    parameter int LD_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ld_en_i,
    input  load_sel_e         ld_sel_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic [LD_W-1:0]   ld_data_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic              mem_we_i,
    input  logic [OPND_W-1:0] mem_addr_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [OPB_W-1:0]  op_word_o,
    output logic [DATA_W-1:0] opnd_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam int JDEPTH = 2 ** (ADDR_W + CC_W);
    localparam int ODEPTH = 2 ** ADDR_W;
    localparam int DDEPTH = 2 ** OPND_W;

    logic [ADDR_W-1:0] jump_mem [JDEPTH];
    logic [OPB_W-1:0]  oper_mem [ODEPTH];
    logic [DATA_W-1:0] data_mem [DDEPTH];

    logic              idx_resv;
    logic [IDX_W-1:0]  jump_rd_idx;

    assign idx_resv    = ld_idx_i[IDX_W-1];
    assign jump_rd_idx = {1'b0, pc_i, cc_i};

    always_ff @(posedge clk_i) begin
        if (ld_en_i && ld_sel_i == LD_JUMP && !idx_resv) begin
            jump_mem[ld_idx_i[IDX_W-2:0]] <= ld_data_i[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (ld_en_i && ld_sel_i == LD_OPER && !idx_resv
            && ld_idx_i[CC_W-1:0] == '0) begin
            oper_mem[ld_idx_i[IDX_W-2:CC_W]] <= ld_data_i[OPB_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (ld_en_i) begin
            if (ld_sel_i == LD_DATA) begin
                data_mem[ld_idx_i[OPND_W-1:0]] <= ld_data_i[DATA_W-1:0];
            end
        end else if (mem_we_i) begin
            data_mem[mem_addr_i] <= mem_data_i;
        end
    end

    assign op_word_o = oper_mem[pc_i];
    assign opnd_o    = data_mem[op_word_o[OPB_W-1:OPB_W-OPND_W]];
    assign next_pc_o = jump_mem[jump_rd_idx[IDX_W-2:0]];

    AST_OPER_RESV_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_en_i && ld_sel_i == LD_OPER && ld_idx_i[CC_W-1:0] != '0)
        |=> $stable(op_word_o)); // R7
    AST_JUMP_RESV_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (ld_en_i && ld_sel_i == LD_JUMP && idx_resv) |=> $stable(next_pc_o)); // R7
endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
    import nbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int OPND_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ld_en_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              dst_mem_i,
    input  logic [OPND_W-1:0] src_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              mem_we_o,
    output logic [OPND_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);
    mode_e mode_q;
    mode_e mode_d;
    logic  exec;

    // Mode state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= ST_SETTLE;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (ld_en_i) begin
            mode_d = ST_FILL;
        end else begin
            unique case (mode_q)
                ST_FILL:   mode_d = ST_SETTLE;
                ST_SETTLE: mode_d = ST_EXEC;
                ST_EXEC:   mode_d = ST_EXEC;
                default:   mode_d = ST_SETTLE;
            endcase
        end
    end

    // Mode-driven outputs
    always_comb begin
        exec       = (mode_q == ST_EXEC) && !ld_en_i;
        mem_we_o   = exec && dst_mem_i;
        mem_addr_o = src_i;
        mem_data_o = res_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_o  <= '0;
            acc_o <= '0;
        end else if (exec) begin
            pc_o <= next_pc_i;
            if (!dst_mem_i) begin
                acc_o <= res_i;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        $past(rst_i) |-> (pc_o == '0 && acc_o == '0)); // R1
    AST_NEXT_FROM_TABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        exec |=> pc_o == $past(next_pc_i)); // R2
    AST_MEM_DEST_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (rst_i)
        (exec && dst_mem_i) |=> $stable(acc_o)); // R4
    AST_LOAD_FREEZES: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_en_i |=> ($stable(pc_o) && $stable(acc_o))); // R6
    AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ld_en_i) |=> ($stable(pc_o) && $stable(acc_o))); // R8
endmodule

// File: rtl/nbc_branch_core.sv
module nbc_branch_core
    import nbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int OPND_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic [1:0]               load_sel,
    input  logic [ADDR_W+CC_W:0]     load_idx,
    input  logic [ADDR_W-1:0]        load_data,
    output logic [ADDR_W-1:0]        pc_o,
    output logic [DATA_W-1:0]        acc_o,
    output logic [CC_W-1:0]          cond_o
);
    localparam int IDX_W = ADDR_W + CC_W + 1;
    localparam int OPB_W = OPND_W + FN_W + 1;

    logic [OPB_W-1:0]  op_word;
    logic [DATA_W-1:0] opnd;
    logic [ADDR_W-1:0] next_pc;
    logic [DATA_W-1:0] alu_res;
    logic              mem_we;
    logic [OPND_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;
    logic [CC_W-1:0]   cc;

    nbc_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPND_W(OPND_W),
        .OPB_W(OPB_W), .IDX_W(IDX_W), .LD_W(ADDR_W)
    ) store_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .ld_en_i    (load_en),
        .ld_sel_i   (load_sel_e'(load_sel)),
        .ld_idx_i   (load_idx),
        .ld_data_i  (load_data),
        .pc_i       (pc),
        .cc_i       (cc),
        .mem_we_i   (mem_we),
        .mem_addr_i (mem_addr),
        .mem_data_i (mem_data),
        .op_word_o  (op_word),
        .opnd_o     (opnd),
        .next_pc_o  (next_pc)
    );

    nbc_alu #(.DATA_W(DATA_W)) alu_i (
        .acc_i  (acc),
        .opnd_i (opnd),
        .op_i   (opcode_e'(op_word[FN_W:1])),
        .res_o  (alu_res),
        .cc_o   (cc)
    );

    nbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPND_W(OPND_W)) seq_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .ld_en_i    (load_en),
        .next_pc_i  (next_pc),
        .res_i      (alu_res),
        .dst_mem_i  (op_word[0]),
        .src_i      (op_word[OPB_W-1:OPB_W-OPND_W]),
        .pc_o       (pc),
        .acc_o      (acc),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_data_o (mem_data)
    );

    assign pc_o   = pc;
    assign acc_o  = acc;
    assign cond_o = cc;
endmodule

// File: tb/nbc_branch_core_tb.sv
`timescale 1ns/1ps
module nbc_branch_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [1:0]  load_sel = 2'b11;
    logic [12:0] load_idx = '0;
    logic [7:0]  load_data = '0;
    logic [7:0]  pc_o;
    logic [3:0]  acc_o;
    logic [3:0]  cond_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state
    int jt [4096];
    int ot [256];
    int dm [16];
    int m_pc = 0, m_acc = 0, m_mode = 1; // 0 fill, 1 settle, 2 exec
    bit ready = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    nbc_branch_core dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_idx(load_idx), .load_data(load_data),
        .pc_o(pc_o), .acc_o(acc_o), .cond_o(cond_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_alu(input int op, input int a, input int b,
                                      output int r, output int cc);
        int x, y, s;
        bit ar, c;
        x = a; y = b; ar = 0; r = a;
        case (op)
            0: ar = 1;
            1: r = (~(a ^ b)) & 15;
            2: begin x = a & b; y = 15; ar = 1; end
            3: r = a & b;
            4: begin x = a | b; y = a; ar = 1; end
            5: r = (a | ~b) & 15;
            6: begin y = 15; ar = 1; end
            default: r = a;
        endcase
        c = 0;
        if (ar) begin
            s = x + y;
            r = s & 15;
            c = (s > 15);
        end
        cc = ((c ? 0 : 1) << 3) | ((r == 15 ? 1 : 0) << 2)
           | (((x & y) != 0 ? 1 : 0) << 1) | ((x | y) == 15 ? 1 : 0);
    endfunction

    // Advance model for the coming edge, then sample after it
    task automatic tick();
        int opw, src, r, cc;
        if (rst) begin
            m_pc = 0; m_acc = 0; m_mode = 1;
        end else if (load_en) begin
            case (load_sel)
                2'b00: if (!load_idx[12]) jt[load_idx[11:0]] = load_data;
                2'b01: if (!load_idx[12] && load_idx[3:0] == 0) ot[load_idx[11:4]] = load_data;
                2'b10: dm[load_idx[3:0]] = load_data & 15;
                default: ;
            endcase
            m_mode = 0;
        end else if (m_mode == 0) begin
            m_mode = 1;
        end else if (m_mode == 1) begin
            m_mode = 2;
        end else begin
            opw = ot[m_pc];
            src = opw >> 4;
            model_alu((opw >> 1) & 7, m_acc, dm[src], r, cc);
            if (opw & 1) dm[src] = r;
            else m_acc = r;
            m_pc = jt[m_pc * 16 + cc];
        end
        @(negedge clk);
        check({phase, " pc"}, pc_o, m_pc);
        check({phase, " acc R3 R4"}, acc_o, m_acc);
        if (ready) begin
            opw = ot[m_pc];
            model_alu((opw >> 1) & 7, m_acc, dm[opw >> 4], r, cc);
            check({phase, " cond R5"}, cond_o, cc);
        end
    endtask

    task automatic load(input int sel, input int idx, input int data);
        load_en = 1; load_sel = sel[1:0]; load_idx = idx[12:0]; load_data = data[7:0];
        tick();
    endtask

    task automatic run(input int n);
        load_en = 0; load_sel = 2'b11;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        @(negedge clk);
        phase = "R1";
        rst = 1;
        tick(); tick();
        check("R1 reset pc", pc_o, 0);
        check("R1 reset acc", acc_o, 0);
        rst = 0;

        // R6: fill all arrays
        phase = "R6 fill";
        for (int i = 0; i < 16; i++) load(2, i, $urandom_range(0, 15));
        for (int i = 0; i < 256; i++) load(1, i << 4, $urandom_range(0, 255));
        for (int i = 0; i < 4096; i++) load(0, i, $urandom_range(0, 255));
        ready = 1;
        load(3, 0, 8'hFF);

        // R7: reserved-index writes must not land
        phase = "R7 resv";
        for (int i = 0; i < 8; i++) load(0, 4096 + $urandom_range(0, 4095), $urandom_range(0, 255));
        for (int i = 0; i < 8; i++) load(1, ($urandom_range(0, 255) << 4) | $urandom_range(1, 15), $urandom_range(0, 255));
        for (int i = 0; i < 8; i++) load(1, 4096 | ($urandom_range(0, 255) << 4), $urandom_range(0, 255));

        // R8: settle gap after load, then run (R2)
        phase = "R8 settle";
        run(2);
        phase = "R2 exec";
        run(2500);

        // R6: load in mid-run, execution frozen
        for (int k = 0; k < 4; k++) begin
            phase = "R6 midload";
            load(2, $urandom_range(0, 15), $urandom_range(0, 15));
            load(1, $urandom_range(0, 255) << 4, $urandom_range(0, 255));
            load(3, 0, 0);
            phase = "R8 resume";
            run(2);
            phase = "R2 exec";
            run(400);
        end

        // R1/R9: reset mid-run keeps tables
        phase = "R1 midreset";
        rst = 1;
        tick();
        check("R1 midreset pc", pc_o, 0);
        check("R1 midreset acc", acc_o, 0);
        rst = 0;
        phase = "R1 first edge idle";
        run(1);
        phase = "R9 after reset";
        run(600);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule